// File: doc/BRIEF.md
# Programmable Sampling Clock Generator

This block produces the conversion-start strobe for a bank of analog-to-digital converters. The strobe can come from two sources. One is an internal chain: a fixed prescaler divides the master clock into a slow tick, and a reloading down counter divides that tick by a programmable rate value. The other is an external sampling clock pin, which is synchronized and edge-detected. A rate value of zero selects the external pin, and any nonzero value selects the internal chain. The chosen strobe passes through one master-clock flop before it leaves the block, so that every strobe is aligned to the master clock.

The strobe can also be driven onto a cascade output through its own enable. Several boards can then run from one sampling clock: the master board drives its cascade pin, and each slave board selects the external source. Software writes the rate value through a small write port and can read it back. Software also writes the cascade enable. Rate values too small for the converters are raised internally to the smallest supported value.

Top module: `samp_clk_gen`

## Requirements
- R1: After reset the rate readback is 0, cnv_start_o is low, and cascade_oe_o is low.
- R2: With a nonzero rate N (15 to 255) written at clock edge E, cnv_start_o is high for the one cycle that follows edge E + 10*(N+1). After that it pulses every 10*(N+1) cycles, where the prescale is 10.
- R3: A rate write reloads the prescaler and the down counter at once. The old period is dropped, and the next strobe follows the R2 timing counted from the write.
- R4: Written rates from 1 to 14 produce the period of rate 15, which is 160 cycles. The readback still returns the written value.
- R5: With the rate at 0, a rising edge on ext_clk_i that is first sampled at edge A gives a single-cycle cnv_start_o in the cycle after edge A+2. The internal chain then produces no strobes.
- R6: ext_clk_i held high gives exactly one strobe. cnv_start_o is never high for two consecutive cycles.
- R7: fs_rdata_o returns the last rate value written, 8 bits wide.
- R8: cascade_oe_o takes the value on cascade_en_i at every cfg_we_i write. cascade_o equals cnv_start_o while cascade_oe_o is 1, and is 0 while it is 0.
- R9: In internal mode, with no rate write in between, two strobes are never closer than 10*(15+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| fs_we_i | input | 1 | rate register write strobe |
| fs_wdata_i | input | 8 | rate value to write (0 selects external clock) |
| fs_rdata_o | output | 8 | rate register readback |
| cfg_we_i | input | 1 | cascade enable write strobe |
| cascade_en_i | input | 1 | cascade enable value to write |
| ext_clk_i | input | 1 | external sampling clock, asynchronous |
| cnv_start_o | output | 1 | conversion-start pulse, one master-clock cycle |
| cascade_o | output | 1 | cascade sampling clock data |
| cascade_oe_o | output | 1 | cascade output drive enable (0 = high impedance) |

## Verification
The bench uses the default parameters: a prescale of 10, an 8-bit rate, a minimum rate of 15 and a two-stage synchronizer. With these values a full slowest period (rate 255, 2560 cycles) fits in a short run, so the bench checks both ends of the rate range for exact strobe cycles. The defaults also keep the synchronizer latency small enough to predict each external strobe to the cycle. A reload in the middle of a period and the clamp of unsupported rates are each checked against predicted strobe cycles.

// File: rtl/samp_clk_pkg.sv
package samp_clk_pkg;
  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} src_e;
endpackage

// File: rtl/samp_prescaler.sv
module samp_prescaler #(
  parameter int DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/samp_rate_cnt.sv
module samp_rate_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] preset_i,
  input  logic         tick_i,
  output logic         strobe_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= preset_i;
    else if (tick_i)  cnt_q <= (cnt_q == '0) ? preset_i : cnt_q - 1'b1;
  end

  assign strobe_o = tick_i && (cnt_q == '0);
endmodule

// File: rtl/samp_edge_sync.sv
module samp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // STAGES sync flops plus one history flop
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/samp_clk_gen.sv
module samp_clk_gen
  import samp_clk_pkg::*;
#(
  parameter int PRESCALE    = 10,
  parameter int FS_W        = 8,
  parameter int FS_MIN      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fs_we_i,
  input  logic [FS_W-1:0] fs_wdata_i,
  output logic [FS_W-1:0] fs_rdata_o,
  input  logic            cfg_we_i,
  input  logic            cascade_en_i,
  input  logic            ext_clk_i,
  output logic            cnv_start_o,
  output logic            cascade_o,
  output logic            cascade_oe_o
);
  localparam logic [FS_W-1:0] MIN_V = FS_W'(FS_MIN);

  function automatic logic [FS_W-1:0] clamp_rate(input logic [FS_W-1:0] v);
    return (v != '0 && v < MIN_V) ? MIN_V : v;
  endfunction

  logic [FS_W-1:0] fs_q;
  logic            oe_q;
  logic            cnv_q;
  logic            tick, int_strobe, ext_rise, sel_strobe;
  logic [FS_W-1:0] preset;
  src_e            src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q <= '0;
      oe_q <= 1'b0;
    end else begin
      if (fs_we_i)  fs_q <= fs_wdata_i;
      if (cfg_we_i) oe_q <= cascade_en_i;
    end
  end

  // reload uses incoming value on the write cycle
  assign preset = clamp_rate(fs_we_i ? fs_wdata_i : fs_q);
  assign src    = (fs_q == '0) ? SRC_EXT : SRC_INT;

  samp_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fs_we_i),
    .tick_o (tick)
  );

  samp_rate_cnt #(.W(FS_W)) u_rate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (fs_we_i),
    .preset_i (preset),
    .tick_i   (tick),
    .strobe_o (int_strobe)
  );

  samp_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_clk_i),
    .rise_o  (ext_rise)
  );

  assign sel_strobe = (src == SRC_INT) ? int_strobe : ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnv_q <= 1'b0;
    else         cnv_q <= sel_strobe;
  end

  assign cnv_start_o  = cnv_q;
  assign cascade_o    = cnv_q & oe_q;
  assign cascade_oe_o = oe_q;
  assign fs_rdata_o   = fs_q;
endmodule

// File: rtl/samp_clk_gen_chk.sv
module samp_clk_gen_chk #(
  parameter int PRESCALE = 10,
  parameter int FS_W     = 8,
  parameter int FS_MIN   = 15
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fs_we_i,
  input logic [FS_W-1:0] fs_wdata_i,
  input logic [FS_W-1:0] fs_rdata_o,
  input logic            cfg_we_i,
  input logic            cascade_en_i,
  input logic            cnv_start_o,
  input logic            cascade_o,
  input logic            cascade_oe_o
);
  localparam int MIN_GAP = PRESCALE * (FS_MIN + 1) - 1;

  int   gap_q;
  logic gap_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= 0;
      gap_vld_q <= 1'b0;
    end else if (fs_we_i) begin
      gap_q     <= 0;
      gap_vld_q <= 1'b0;
    end else if (cnv_start_o) begin
      gap_q     <= 0;
      gap_vld_q <= 1'b1;
    end else if (gap_q < MIN_GAP + 1) begin
      gap_q <= gap_q + 1;
    end
  end

  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_start_o |=> !cnv_start_o);

  // R7
  fs_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_we_i |=> fs_rdata_o == $past(fs_wdata_i));

  // R8
  cascade_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cascade_oe_o == $past(cascade_en_i));

  // R8
  cascade_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cascade_oe_o |-> !cascade_o);

  // R8
  cascade_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_oe_o |-> cascade_o == cnv_start_o);

  // R9
  min_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnv_start_o && gap_vld_q && fs_rdata_o != '0) |-> gap_q >= MIN_GAP);
endmodule

bind samp_clk_gen samp_clk_gen_chk #(
  .PRESCALE (PRESCALE),
  .FS_W     (FS_W),
  .FS_MIN   (FS_MIN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fs_we_i      (fs_we_i),
  .fs_wdata_i   (fs_wdata_i),
  .fs_rdata_o   (fs_rdata_o),
  .cfg_we_i     (cfg_we_i),
  .cascade_en_i (cascade_en_i),
  .cnv_start_o  (cnv_start_o),
  .cascade_o    (cascade_o),
  .cascade_oe_o (cascade_oe_o)
);

// File: tb/sim_samp_clk_gen.sv
module sim_samp_clk_gen;
  localparam int P = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fs_we_i = 1'b0;
  logic [7:0] fs_wdata_i = '0;
  logic [7:0] fs_rdata_o;
  logic       cfg_we_i = 1'b0;
  logic       cascade_en_i = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       cnv_start_o, cascade_o, cascade_oe_o;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    exp_q[$];
  string cur_req = "R2";
  bit    exp_oe = 1'b0;
  bit    done = 1'b0;

  samp_clk_gen u0 (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: scoreboard pop on every strobe
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (cnv_start_o) begin
        if (exp_q.size() == 0) chk(1'b0, cur_req, "unexpected strobe at cycle", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, cur_req, "strobe cycle", cyc, e);
        end
        chk(cascade_o == exp_oe, "R8", "cascade data on strobe", int'(cascade_o), int'(exp_oe));
      end else if (cascade_o) begin
        chk(1'b0, "R8", "cascade high without strobe", 1, 0);
      end
    end
  end

  task automatic wr_fs(input logic [7:0] d, output int e0);
    @(negedge clk_i);
    fs_we_i = 1'b1; fs_wdata_i = d; e0 = cyc + 1;
    @(negedge clk_i);
    fs_we_i = 1'b0;
  endtask

  task automatic wr_cfg(input bit en);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cascade_en_i = en;
    @(negedge clk_i);
    cfg_we_i = 1'b0; exp_oe = en;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
  endtask

  task automatic run_rate(input logic [7:0] d, input int eff, input int n, input string req);
    int e0;
    cur_req = req;
    wr_fs(d, e0);
    chk(fs_rdata_o == d, "R7", "readback", fs_rdata_o, d);
    for (int k = 1; k <= n; k++) exp_q.push_back(e0 + P * (eff + 1) * k);
    drain();
  endtask

  task automatic ext_pulse(input int hold);
    @(negedge clk_i);
    ext_clk_i = 1'b1;
    exp_q.push_back(cyc + 3);
    repeat (hold) @(negedge clk_i);
    ext_clk_i = 1'b0;
    repeat (6) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(fs_rdata_o == 0, "R1", "reset rate", fs_rdata_o, 0);
    chk(cnv_start_o == 0, "R1", "reset strobe", cnv_start_o, 0);
    chk(cascade_oe_o == 0, "R1", "reset cascade oe", cascade_oe_o, 0);
    rst_ni = 1'b1;

    // R5 external mode, R6 long high gives one strobe
    cur_req = "R5";
    ext_pulse(1);
    ext_pulse(4);
    cur_req = "R6";
    ext_pulse(40);
    drain();
    repeat (300) @(negedge clk_i);  // R5: internal chain silent

    // R2 internal periods, both ends
    run_rate(8'd15, 15, 3, "R2");
    run_rate(8'd40, 40, 2, "R2");

    // R3 reload mid period
    begin
      int e0;
      cur_req = "R3";
      wr_fs(8'd20, e0);
      exp_q.push_back(e0 + P * 21);
      drain();
      repeat (50) @(negedge clk_i);
      wr_fs(8'd30, e0);
      exp_q.push_back(e0 + P * 31);
      exp_q.push_back(e0 + P * 31 * 2);
      drain();
    end

    // R4 clamp of unsupported values
    run_rate(8'd3, 15, 2, "R4");
    run_rate(8'd14, 15, 1, "R4");
    run_rate(8'd1, 15, 1, "R4");

    // R8 cascade enabled for a run
    wr_cfg(1'b1);
    chk(cascade_oe_o == 1, "R8", "cascade oe set", cascade_oe_o, 1);
    run_rate(8'd255, 255, 2, "R2");
    wr_cfg(1'b0);
    chk(cascade_oe_o == 0, "R8", "cascade oe cleared", cascade_oe_o, 0);
    run_rate(8'd16, 16, 2, "R9");

    // back to external: internal chain stops
    begin
      int e0;
      wr_fs(8'd0, e0);
      chk(fs_rdata_o == 0, "R7", "readback zero", fs_rdata_o, 0);
      repeat (6) @(negedge clk_i);
      cur_req = "R5";
      repeat (400) @(negedge clk_i);
      ext_pulse(2);
      drain();
    end

    repeat (20) @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule